// File: doc/BRIEF.md
# Two-pass multiply-accumulate unit

This unit multiplies two 32-bit operands and either loads, adds to or subtracts from a 64-bit high/low accumulator pair, or returns the low word of the product as a general-register result. All work goes through one radix-4 Booth multiplier array that takes the full first operand and 16 bits of the second. The second operand is the only one examined. When it fits in 16 bits, the operation makes one pass through the array. When it does not fit, the low half of the second operand goes through the array first. The high half follows in the next cycle, and its partial product is shifted left by 16 bits.

A partial product leaves the array through a pipeline register. A separate final-add stage then combines the halves and updates the accumulator or the result port. The `ready_o` output drops for the single cycle in which a second pass holds the array. As a result, one-pass operations can issue every clock and two-pass operations can issue every other clock. An operation is accepted at a rising edge where `valid_i` and `ready_o` are both high.

Top module: `mac_unit`

## Requirements
- R1: While reset is held and after it is released, `hi_o` and `lo_o` are zero, `ready_o` is 1 and `gpr_valid_o` is 0.
- R2: The second operand fits when its upper 16 bits all equal its bit 15 (signed ops) or are all zero (unsigned ops). A fitting operation makes one pass, and its result appears after the second rising edge following acceptance.
- R3: A non-fitting operation makes two passes. `ready_o` is 0 for exactly the one cycle after acceptance, and the result appears after the third rising edge following acceptance.
- R4: `op_i` encoding is 0 MULT, 1 MULTU, 2 MADD, 3 MADDU, 4 MSUB, 5 MSUBU, 6 MUL, 7 no operation. MULT and MULTU load {`hi_o`,`lo_o`} with the signed and unsigned 64-bit product respectively, with `hi_o` holding the upper word.
- R5: MADD and MADDU add the signed or unsigned 64-bit product to {`hi_o`,`lo_o`}, modulo 2^64.
- R6: MSUB and MSUBU subtract the signed or unsigned 64-bit product from {`hi_o`,`lo_o`}, modulo 2^64.
- R7: MUL drives `gpr_result_o` with the low 32 bits of the signed product. It raises `gpr_valid_o` for one cycle at the time the result appears, as given by R2 and R3, and leaves `hi_o` and `lo_o` unchanged.
- R8: One-pass operations accepted on consecutive edges are all applied to the accumulator in issue order.
- R9: `valid_i` is ignored while `ready_o` is 0, and the operation on the inputs at that time has no effect.
- R10: Op code 7 changes neither {`hi_o`,`lo_o`} nor `gpr_valid_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation request |
| op_i | input | 3 | Operation code |
| rs_i | input | 32 | First operand (full width in the array) |
| rt_i | input | 32 | Second operand (examined for width) |
| ready_o | output | 1 | New operation can be accepted |
| hi_o | output | 32 | Upper accumulator word |
| lo_o | output | 32 | Lower accumulator word |
| gpr_valid_o | output | 1 | General-register result strobe |
| gpr_result_o | output | 32 | Low product word for MUL |

## Verification
The hardest case to reach is a request that arrives during the one stall cycle of a two-pass operation. The bench produces it by holding `valid_i` high with a different accumulate operation through that cycle, and then checks that the accumulator carries only the first result. The boundary of the width check is also exercised. Second operands just inside and just outside the 16-bit range are used, including 0x80000000, 0xFFFF8000 and 0x00008000, under both signed and unsigned codes. Random operand pairs, biased toward narrow values and the most negative number, are checked against a 64-bit reference product.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_MULT  = 3'd0,
    OP_MULTU = 3'd1,
    OP_MADD  = 3'd2,
    OP_MADDU = 3'd3,
    OP_MSUB  = 3'd4,
    OP_MSUBU = 3'd5,
    OP_MUL   = 3'd6,
    OP_NOP   = 3'd7
  } mac_op_e;

  function automatic logic op_signed(input logic [2:0] op);
    return (op == OP_MULT) || (op == OP_MADD) || (op == OP_MSUB) || (op == OP_MUL);
  endfunction
endpackage

// File: rtl/mac_rt_fit.sv
module mac_rt_fit #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] rt_i,
  input  logic              sgn_i,
  output logic              fit_o
);
  localparam int unsigned HALF = DATA_W / 2;
  logic [DATA_W-HALF-1:0] upper;
  assign upper = rt_i[DATA_W-1:HALF];
  assign fit_o = sgn_i ? ((&upper & rt_i[HALF-1]) | (~|upper & ~rt_i[HALF-1])) : ~|upper;
endmodule

// File: rtl/mac_booth_array.sv
module mac_booth_array #(
  parameter int unsigned A_W = 33,
  parameter int unsigned B_W = 17,
  parameter int unsigned P_W = 64
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  localparam int unsigned NGRP = (B_W + 1) / 2;
  localparam int unsigned BX_W = 2 * NGRP;

  function automatic logic [P_W-1:0] booth_pp(input logic [2:0] t, input logic [P_W-1:0] a);
    case (t)
      3'b001, 3'b010: return a;
      3'b011:         return a << 1;
      3'b100:         return -(a << 1);
      3'b101, 3'b110: return -a;
      default:        return '0;
    endcase
  endfunction

  logic [P_W-1:0]  a_ext;
  logic [BX_W:0]   bx;
  logic [P_W-1:0]  pp [NGRP];

  assign a_ext = {{(P_W-A_W){a_i[A_W-1]}}, a_i};
  assign bx    = {{(BX_W-B_W){b_i[B_W-1]}}, b_i, 1'b0};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign pp[g] = booth_pp(bx[2*g+2:2*g], a_ext) << (2*g);
  end

  always_comb begin
    p_o = '0;
    for (int i = 0; i < NGRP; i++) p_o = p_o + pp[i];
  end
endmodule

// File: rtl/mac_cpa.sv
module mac_cpa
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned P_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pp_valid_i,
  input  logic [P_W-1:0]    pp_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [2:0]        op_i,
  output logic [P_W-1:0]    hilo_o,
  output logic              gpr_valid_o,
  output logic [DATA_W-1:0] gpr_result_o
);
  logic [P_W-1:0] hilo_q, tmp_q, prod;

  assign prod = first_i ? pp_i : tmp_q + pp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hilo_q       <= '0;
      tmp_q        <= '0;
      gpr_valid_o  <= 1'b0;
      gpr_result_o <= '0;
    end else begin
      gpr_valid_o <= 1'b0;
      if (pp_valid_i && first_i && !last_i) tmp_q <= pp_i;
      if (pp_valid_i && last_i) begin
        case (mac_op_e'(op_i))
          OP_MULT, OP_MULTU: hilo_q <= prod;
          OP_MADD, OP_MADDU: hilo_q <= hilo_q + prod;
          OP_MSUB, OP_MSUBU: hilo_q <= hilo_q - prod;
          OP_MUL: begin
            gpr_valid_o  <= 1'b1;
            gpr_result_o <= prod[DATA_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  assign hilo_o = hilo_q;
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              gpr_valid_o,
  output logic [DATA_W-1:0] gpr_result_o
);
  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned A_W  = DATA_W + 1;
  localparam int unsigned B_W  = HALF + 1;
  localparam int unsigned P_W  = 2 * DATA_W;

  logic            pend_q;
  logic [A_W-1:0]  rs_q;
  logic [B_W-1:0]  rt_hi_q;
  logic [2:0]      op_q;

  logic            accept, sgn, fit;
  logic [A_W-1:0]  arr_a;
  logic [B_W-1:0]  arr_b;
  logic [P_W-1:0]  arr_p, arr_sh;
  logic            arr_vld, arr_first, arr_last;
  logic [2:0]      arr_op;

  logic            s1_vld, s1_first, s1_last;
  logic [P_W-1:0]  s1_pp;
  logic [2:0]      s1_op;
  logic [P_W-1:0]  hilo;

  assign ready_o = ~pend_q;
  assign accept  = valid_i & ready_o;
  assign sgn     = op_signed(op_i);

  mac_rt_fit #(.DATA_W(DATA_W)) i_fit (.rt_i(rt_i), .sgn_i(sgn), .fit_o(fit));

  always_comb begin
    if (pend_q) begin
      arr_a     = rs_q;
      arr_b     = rt_hi_q;
      arr_vld   = 1'b1;
      arr_first = 1'b0;
      arr_last  = 1'b1;
      arr_op    = op_q;
    end else begin
      arr_a     = {sgn & rs_i[DATA_W-1], rs_i};
      // low half is unsigned when a high pass follows
      arr_b     = {fit & sgn & rt_i[HALF-1], rt_i[HALF-1:0]};
      arr_vld   = accept;
      arr_first = 1'b1;
      arr_last  = fit;
      arr_op    = op_i;
    end
  end

  mac_booth_array #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) i_array (
    .a_i(arr_a), .b_i(arr_b), .p_o(arr_p)
  );

  assign arr_sh = pend_q ? (arr_p << HALF) : arr_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      rs_q     <= '0;
      rt_hi_q  <= '0;
      op_q     <= '0;
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_pp    <= '0;
      s1_op    <= '0;
    end else begin
      pend_q <= accept & ~fit;
      if (accept) begin
        rs_q    <= {sgn & rs_i[DATA_W-1], rs_i};
        rt_hi_q <= {sgn & rt_i[DATA_W-1], rt_i[DATA_W-1:HALF]};
        op_q    <= op_i;
      end
      s1_vld   <= arr_vld;
      s1_first <= arr_first;
      s1_last  <= arr_last;
      s1_pp    <= arr_sh;
      s1_op    <= arr_op;
    end
  end

  mac_cpa #(.DATA_W(DATA_W)) i_cpa (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pp_valid_i(s1_vld), .pp_i(s1_pp), .first_i(s1_first), .last_i(s1_last), .op_i(s1_op),
    .hilo_o(hilo), .gpr_valid_o(gpr_valid_o), .gpr_result_o(gpr_result_o)
  );

  assign hi_o = hilo[P_W-1:DATA_W];
  assign lo_o = hilo[DATA_W-1:0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] rs_i,
  input logic [DATA_W-1:0] rt_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] hi_o,
  input logic [DATA_W-1:0] lo_o,
  input logic              gpr_valid_o,
  input logic [DATA_W-1:0] gpr_result_o
);
  localparam int unsigned HALF = DATA_W / 2;
  logic                  acc, narrow;
  logic [2*DATA_W-1:0]   sprod;

  assign acc    = valid_i && ready_o;
  assign narrow = op_signed(op_i)
                ? (rt_i[DATA_W-1:HALF-1] == '0 || rt_i[DATA_W-1:HALF-1] == '1)
                : (rt_i[DATA_W-1:HALF] == '0);
  assign sprod  = $signed({{DATA_W{rs_i[DATA_W-1]}}, rs_i}) * $signed({{DATA_W{rt_i[DATA_W-1]}}, rt_i});

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (ready_o && !gpr_valid_o && hi_o == '0 && lo_o == '0);
    end
  end

  // R3
  wide_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !narrow) |=> !ready_o);

  // R3
  stall_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);

  // R2
  narrow_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && narrow) |=> ready_o);

  // R4
  mult_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && narrow && op_i == OP_MULT) |-> ##2 ({hi_o, lo_o} == $past(sprod, 2)));

  // R7
  mul_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && narrow && op_i == OP_MUL) |-> ##2 (gpr_valid_o && gpr_result_o == $past(sprod[DATA_W-1:0], 2)));

  // R7
  mul_keeps_hilo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_valid_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W)) i_mac_unit_chk (.*);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = 3'd7;
  logic [31:0] rs = '0, rt = '0;
  logic        ready;
  logic [31:0] hi, lo, gres;
  logic        gvld;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] model = '0;
  logic [31:0] exp_gpr = '0;

  always #2.5 clk = ~clk;

  mac_unit i_mac_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .rs_i(rs), .rt_i(rt),
    .ready_o(ready), .hi_o(hi), .lo_o(lo), .gpr_valid_o(gvld), .gpr_result_o(gres)
  );

  function automatic bit is_sgn(input logic [2:0] o);
    return o == 3'd0 || o == 3'd2 || o == 3'd4 || o == 3'd6;
  endfunction

  function automatic logic [63:0] ref_prod(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    if (is_sgn(o)) return $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return {32'd0, a} * {32'd0, b};
  endfunction

  task automatic model_apply(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p = ref_prod(o, a, b);
    case (o)
      3'd0, 3'd1: model = p;
      3'd2, 3'd3: model = model + p;
      3'd4, 3'd5: model = model - p;
      3'd6:       exp_gpr = p[31:0];
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives one op; returns at the first negedge after the accepting edge
  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1; op = o; rs = a; rt = b;
    model_apply(o, a, b);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] old;
    void'($urandom(32'h1bad_5eed));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset hilo", {hi, lo}, 64'd0);
    chk("R1 reset ready/gvld", {63'd0, ready, gvld} , {63'd0, 2'b10});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {hi, lo, 30'd0, ready, gvld}, {64'd0, 30'd0, 2'b10});

    // R2 narrow signed timing
    old = {hi, lo};
    issue(3'd0, 32'h8000_0000, 32'hFFFF_8000);
    chk("R2 narrow ready", {63'd0, ready}, 64'd1);
    chk("R2 narrow not yet", {hi, lo}, old);
    @(negedge clk);
    chk("R2 narrow result", {hi, lo}, model);

    // R3 wide timing: 0x00008000 is wide for signed ops
    old = {hi, lo};
    issue(3'd0, 32'h1234_5678, 32'h0000_8000);
    chk("R3 wide stall", {63'd0, ready}, 64'd0);
    @(negedge clk);
    chk("R3 ready back", {63'd0, ready}, 64'd1);
    chk("R3 wide not yet", {hi, lo}, old);
    @(negedge clk);
    chk("R3 wide result", {hi, lo}, model);

    // R2 same value is narrow for unsigned
    issue(3'd1, 32'hFFFF_FFFF, 32'h0000_8000);
    chk("R2 unsigned narrow ready", {63'd0, ready}, 64'd1);
    settle();
    chk("R4 multu", {hi, lo}, model);

    // R4 most negative both operands, wide
    issue(3'd0, 32'h8000_0000, 32'h8000_0000);
    settle();
    chk("R4 mult min*min", {hi, lo}, model);
    issue(3'd1, 32'h8000_0000, 32'hFFFF_FFFF);
    settle();
    chk("R4 multu wide", {hi, lo}, model);

    // R5 / R6
    issue(3'd2, 32'hFFFF_FFF0, 32'h0001_0003);
    settle();
    chk("R5 madd", {hi, lo}, model);
    issue(3'd3, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    settle();
    chk("R5 maddu", {hi, lo}, model);
    issue(3'd4, 32'h7FFF_FFFF, 32'h8000_0000);
    settle();
    chk("R6 msub", {hi, lo}, model);
    issue(3'd5, 32'h0000_1234, 32'h0000_ABCD);
    settle();
    chk("R6 msubu", {hi, lo}, model);

    // R7 narrow MUL
    old = {hi, lo};
    issue(3'd6, 32'hFFFF_FFFD, 32'h0000_7FFF);
    chk("R7 no early strobe", {63'd0, gvld}, 64'd0);
    @(negedge clk);
    chk("R7 strobe", {63'd0, gvld}, 64'd1);
    chk("R7 gpr value", {32'd0, gres}, {32'd0, exp_gpr});
    chk("R7 hilo kept", {hi, lo}, old);
    @(negedge clk);
    chk("R7 strobe one cycle", {63'd0, gvld}, 64'd0);
    // R7 wide MUL
    issue(3'd6, 32'h0BAD_F00D, 32'h8765_4321);
    @(negedge clk);
    chk("R7 wide no early strobe", {63'd0, gvld}, 64'd0);
    @(negedge clk);
    chk("R7 wide strobe", {63'd0, gvld, gres}, {31'd0, 1'b1, exp_gpr});
    chk("R7 wide hilo kept", {hi, lo}, old);

    // R8 back-to-back narrow ops
    @(negedge clk);
    valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      op = (k == 0) ? 3'd0 : ((k[0]) ? 3'd2 : 3'd4);
      rs = $urandom;
      rt = {{16{1'b0}}, 1'b0, 15'($urandom)};
      model_apply(op, rs, rt);
      @(negedge clk);
      chk("R8 ready each cycle", {63'd0, ready}, 64'd1);
    end
    valid = 1'b0;
    settle();
    chk("R8 in-order result", {hi, lo}, model);

    // R9 request during stall is ignored
    issue(3'd2, 32'h8000_0000, 32'h4000_0001);
    valid = 1'b1; op = 3'd0; rs = 32'h5; rt = 32'h7;
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    chk("R9 stall request ignored", {hi, lo}, model);

    // R10 nop op code
    old = {hi, lo};
    issue(3'd7, 32'hFFFF_FFFF, 32'h1234_5678);
    settle();
    chk("R10 nop hilo", {hi, lo}, old);
    chk("R10 nop gvld", {63'd0, gvld}, 64'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  ro;
      logic [31:0] ra, rb;
      ro = 3'($urandom % 7);
      ra = ($urandom % 8 == 0) ? 32'h8000_0000 : $urandom;
      case ($urandom % 4)
        0: rb = {{16{rb[15]}}, 16'($urandom)};
        1: rb = 32'h8000_0000;
        2: rb = {16'd0, 16'($urandom)};
        default: rb = $urandom;
      endcase
      if (rb[31:16] != '0 && rb[31:16] != '1) rb = rb;
      rb = (n % 4 == 0) ? {{16{rb[15]}}, rb[15:0]} : rb;
      issue(ro, ra, rb);
      settle();
      if (ro == 3'd6) chk("R7 random mul", {32'd0, gres}, {32'd0, exp_gpr});
      else if (ro < 3'd2) chk("R4 random", {hi, lo}, model);
      else if (ro < 3'd4) chk("R5 random", {hi, lo}, model);
      else chk("R6 random", {hi, lo}, model);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule